// File: doc/BRIEF.md
# Asymmetric Decode Group Steering

This block takes a group of up to four already classified macro-instructions each cycle and decides how many of them enter decode together. The decode slots are not equal. Slot 0 can take a complex instruction that expands to one to four micro-ops. Slots 1 to 3 take only single micro-op instructions. When a slot after slot 0 holds anything other than a simple instruction, the group ends in front of it. That instruction then moves to slot 0 on a later cycle. For each accepted group the block reports which decode slots are filled, the total micro-op count and how many macro-instructions were used. Upstream logic advances its queue pointer by that last count.

An instruction that needs more micro-ops than slot 0 can emit is handed to a microcode sequencer. The block then accepts no decode group until the sequencer pulses done. A flush drops whatever group is presented in that cycle and cancels an active sequencer hand-off.

The decoded group is a valid/ready stream. `out_valid` never depends on `out_ready`. While `out_ready` is low, the presented group is held and nothing is consumed (`take_cnt` = 0), so no group is ever partly taken. The upstream side has no handshake of its own: it keeps its instructions in place and advances by `take_cnt` each cycle.

Top module: `dsteer_top`

## Requirements
- R1: Slot 0 accepts a simple instruction (class 0, one micro-op) or a complex one (class 1, micro-op count taken from its 3-bit count field, 1 to 4). Whenever a group is offered, bit 0 of `out_slots` is set.
- R2: Slot i (i > 0) joins the group only if every lower slot joined and slot i is valid with class 0. The first valid non-simple instruction ends the group, so `out_slots` is a contiguous mask from bit 0. Slot i uses class bits [2i+1:2i] and count bits [3i+2:3i].
- R3: `out_uops` equals slot 0's micro-op count plus one for each other slot in the group. It is 0 when no group is offered. Count fields of simple instructions are ignored.
- R4: While `out_valid` is high and `out_ready` is low, `take_cnt` is 0 and the offered group stays unchanged for unchanged inputs.
- R5: On a handshake (`out_valid` and `out_ready`), `take_cnt` equals the number of slots in the group.
- R6: A valid slot-0 instruction of class 2 or 3 (microcoded) while idle and not flushing raises `mseq_start` for one cycle with `take_cnt` = 1 and `out_valid` low, whatever `out_ready` is.
- R7: From the cycle after `mseq_start` until the cycle after `mseq_done`, `out_valid`, `mseq_start` and `take_cnt` stay 0.
- R8: With `flush` high, `out_valid`, `mseq_start` and `take_cnt` are 0. `mseq_abort` is high if a sequencer hand-off is active, and the block is idle in the next cycle.
- R9: After reset no hand-off is active, and with no valid input all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Drop current group, cancel sequencer hand-off |
| grp_vld | input | 4 | Per-slot valid, contiguous from slot 0 |
| grp_cls | input | 8 | Per-slot 2-bit class: 0 simple, 1 complex, 2/3 microcoded |
| grp_ucnt | input | 12 | Per-slot 3-bit micro-op count (used for a complex slot 0) |
| take_cnt | output | 3 | Macro-instructions consumed this cycle |
| out_valid | output | 1 | A decode group is offered |
| out_ready | input | 1 | Downstream accepts the group |
| out_slots | output | 4 | Mask of filled decode slots |
| out_uops | output | 3 | Total micro-ops in the offered group |
| mseq_start | output | 1 | Hand slot-0 instruction to microcode sequencer |
| mseq_done | input | 1 | Sequencer finished streaming |
| mseq_abort | output | 1 | Active hand-off cancelled by flush |

## Verification
The bench builds the block with its default parameters: four slots and a complex decoder limit of four micro-ops. With these values every group length from one to four can be reached, along with every micro-op total from one to seven. The stimulus includes a complex slot 0 at the full limit followed by three simple slots, which reaches the widest `out_uops` value. Random groups mix the three classes in every position, with back-pressure, done pulses and flushes arriving during and outside sequencer hand-offs.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
  typedef enum logic [1:0] {
    CLS_SIMPLE  = 2'd0,
    CLS_COMPLEX = 2'd1,
    CLS_MSEQ    = 2'd2,
    CLS_MSEQ_X  = 2'd3
  } icls_e;

  function automatic logic is_decodable(input logic [1:0] c);
    return (c == CLS_SIMPLE) || (c == CLS_COMPLEX);
  endfunction
endpackage

// File: rtl/dsteer_group_scan.sv
module dsteer_group_scan import dsteer_pkg::*; #(
  parameter int SLOTS = 4
) (
  input  logic [SLOTS-1:0]   vld,
  input  logic [2*SLOTS-1:0] cls,
  output logic [SLOTS-1:0]   join_mask,
  output logic               lead_mseq
);
  assign join_mask[0] = vld[0] && is_decodable(cls[1:0]);
  assign lead_mseq    = vld[0] && !is_decodable(cls[1:0]);

  for (genvar i = 1; i < SLOTS; i++) begin : g_slot
    assign join_mask[i] = join_mask[i-1] && vld[i] &&
                          (icls_e'(cls[2*i +: 2]) == CLS_SIMPLE);
  end
endmodule

// File: rtl/dsteer_uop_sum.sv
module dsteer_uop_sum import dsteer_pkg::*; #(
  parameter int SLOTS       = 4,
  parameter int MAX_CX_UOPS = 4,
  localparam int CW  = $clog2(MAX_CX_UOPS + 1),
  localparam int UOW = $clog2(MAX_CX_UOPS + SLOTS),
  localparam int TW  = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0] join_mask,
  input  logic [1:0]       lead_cls,
  input  logic [CW-1:0]    lead_cnt,
  output logic [UOW-1:0]   uops,
  output logic [TW-1:0]    glen
);
  logic [UOW-1:0] lead_uops;
  logic [TW-1:0]  tail;

  always_comb begin
    tail = '0;
    for (int i = 1; i < SLOTS; i++) tail += TW'(join_mask[i]);
  end

  always_comb begin
    if (!join_mask[0])                                lead_uops = '0;
    else if (icls_e'(lead_cls) == CLS_COMPLEX)        lead_uops = UOW'(lead_cnt);
    else                                              lead_uops = UOW'(1);
  end

  assign uops = lead_uops + UOW'(tail);
  assign glen = join_mask[0] ? tail + TW'(1) : '0;
endmodule

// File: rtl/dsteer_mseq_ctl.sv
module dsteer_mseq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic done,
  input  logic flush,
  output logic busy,
  output logic abort
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy <= 1'b0;
    else if (flush)  busy <= 1'b0;
    else if (busy)   busy <= !done;
    else             busy <= start;
  end

  assign abort = flush && busy;

  // R8
  flush_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);
  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !flush |=> busy);
  // R6
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !flush |=> busy);
endmodule

// File: rtl/dsteer_top.sv
module dsteer_top import dsteer_pkg::*; #(
  parameter int SLOTS       = 4,
  parameter int MAX_CX_UOPS = 4,
  localparam int CW  = $clog2(MAX_CX_UOPS + 1),
  localparam int UOW = $clog2(MAX_CX_UOPS + SLOTS),
  localparam int TW  = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic [SLOTS-1:0]      grp_vld,
  input  logic [2*SLOTS-1:0]    grp_cls,
  input  logic [CW*SLOTS-1:0]   grp_ucnt,
  output logic [TW-1:0]         take_cnt,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SLOTS-1:0]      out_slots,
  output logic [UOW-1:0]        out_uops,
  output logic                  mseq_start,
  input  logic                  mseq_done,
  output logic                  mseq_abort
);
  logic [SLOTS-1:0] join_mask;
  logic             lead_mseq;
  logic [UOW-1:0]   uops;
  logic [TW-1:0]    glen;
  logic             busy;
  logic             gate;

  dsteer_group_scan #(.SLOTS(SLOTS)) u_scan (
    .vld(grp_vld), .cls(grp_cls), .join_mask(join_mask), .lead_mseq(lead_mseq)
  );

  dsteer_uop_sum #(.SLOTS(SLOTS), .MAX_CX_UOPS(MAX_CX_UOPS)) u_sum (
    .join_mask(join_mask), .lead_cls(grp_cls[1:0]), .lead_cnt(grp_ucnt[CW-1:0]),
    .uops(uops), .glen(glen)
  );

  dsteer_mseq_ctl u_mseq (
    .clk(clk), .rst_n(rst_n), .start(mseq_start), .done(mseq_done),
    .flush(flush), .busy(busy), .abort(mseq_abort)
  );

  assign gate       = !busy && !flush;
  assign out_valid  = gate && join_mask[0];
  assign out_slots  = out_valid ? join_mask : '0;
  assign out_uops   = out_valid ? uops : '0;
  assign mseq_start = gate && lead_mseq;

  always_comb begin
    if (out_valid && out_ready) take_cnt = glen;
    else if (mseq_start)        take_cnt = TW'(1);
    else                        take_cnt = '0;
  end

  // R4
  hold_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> take_cnt == '0);
  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid && !mseq_start && take_cnt == '0);
  // R2
  slots_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_slots + SLOTS'(1)) & out_slots) == '0);
  // R5
  take_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(take_cnt) <= $countones(grp_vld));
  // R8
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !out_valid && !mseq_start && take_cnt == '0);
endmodule

// File: tb/dsteer_top_tb_top.sv
module dsteer_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [3:0]  grp_vld = '0;
  logic [7:0]  grp_cls = '0;
  logic [11:0] grp_ucnt = '0;
  logic        out_ready = 1'b1;
  logic        mseq_done = 1'b0;
  logic [2:0]  take_cnt;
  logic        out_valid;
  logic [3:0]  out_slots;
  logic [2:0]  out_uops;
  logic        mseq_start;
  logic        mseq_abort;

  int n_run = 0;
  int n_fail = 0;
  bit m_busy = 0;

  always #10 clk = ~clk;

  dsteer_top dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .grp_vld(grp_vld),
    .grp_cls(grp_cls), .grp_ucnt(grp_ucnt), .take_cnt(take_cnt),
    .out_valid(out_valid), .out_ready(out_ready), .out_slots(out_slots),
    .out_uops(out_uops), .mseq_start(mseq_start), .mseq_done(mseq_done),
    .mseq_abort(mseq_abort)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int glen, uops, et;
    bit ev, es, ea, stop;
    #8;
    ev = !m_busy && !flush && grp_vld[0] && (grp_cls[1:0] < 2);
    es = !m_busy && !flush && grp_vld[0] && (grp_cls[1:0] >= 2);
    ea = flush && m_busy;
    glen = 0; stop = 0;
    if (ev) begin
      glen = 1;
      for (int i = 1; i < 4; i++) begin
        if (!stop && grp_vld[i] && grp_cls[2*i +: 2] == 2'd0) glen++;
        else stop = 1;
      end
    end
    uops = ev ? ((grp_cls[1:0] == 2'd1 ? int'(grp_ucnt[2:0]) : 1) + glen - 1) : 0;
    et = (ev && out_ready) ? glen : (es ? 1 : 0);
    chk("R7 out_valid", int'(out_valid), int'(ev));
    chk("R2 out_slots", int'(out_slots), (1 << glen) - 1);
    chk("R3 out_uops", int'(out_uops), uops);
    chk("R5 take_cnt", int'(take_cnt), et);
    chk("R6 mseq_start", int'(mseq_start), int'(es));
    chk("R8 mseq_abort", int'(mseq_abort), int'(ea));
    if (ev) chk("R1 slot0", int'(out_slots[0]), 1);
    if (ev && !out_ready) chk("R4 hold", int'(take_cnt), 0);
    @(posedge clk);
    if (flush) m_busy = 0;
    else if (m_busy) m_busy = !mseq_done;
    else m_busy = es;
    @(negedge clk);
  endtask

  task automatic set_grp(input logic [3:0] v, input logic [7:0] c, input logic [11:0] u);
    grp_vld = v; grp_cls = c; grp_ucnt = u;
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state, no valid input
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 take_cnt", int'(take_cnt), 0);
    chk("R9 mseq_start", int'(mseq_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc();
    // R3: four simple, counts ignored
    set_grp(4'hF, 8'h00, 12'hFFF); cyc();
    // R1/R3: complex of 4 plus three simple -> 7
    set_grp(4'hF, 8'h01, 12'h004); cyc();
    // R2: complex in slot 2 ends group at 2
    set_grp(4'hF, 8'h10, 12'h000); cyc();
    // R2: microcoded in slot 1 ends group at 1
    set_grp(4'h7, 8'h09, 12'h003); cyc();
    // R4: back-pressure holds group, twice
    out_ready = 1'b0; set_grp(4'h3, 8'h01, 12'h002); cyc(); cyc();
    out_ready = 1'b1; cyc();
    // R6/R7: microcoded lead, busy until done
    set_grp(4'h3, 8'h02, 12'h000); cyc();
    set_grp(4'hF, 8'h00, 12'h000); cyc(); cyc();
    mseq_done = 1'b1; cyc(); mseq_done = 1'b0; cyc();
    // R8: flush during hand-off
    set_grp(4'h1, 8'h03, 12'h000); cyc();
    flush = 1'b1; set_grp(4'hF, 8'h00, 12'h000); cyc();
    flush = 1'b0; cyc();
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int n;
      n = $urandom_range(0, 4);
      grp_vld = 4'((1 << n) - 1);
      for (int i = 0; i < 4; i++) begin
        int r;
        r = $urandom_range(0, 9);
        grp_cls[2*i +: 2] = (r < 6) ? 2'd0 : (r < 9) ? 2'd1 : 2'($urandom_range(2, 3));
        grp_ucnt[3*i +: 3] = (grp_cls[2*i +: 2] == 2'd1) ? 3'($urandom_range(1, 4))
                                                         : 3'($urandom_range(0, 7));
      end
      out_ready = ($urandom_range(0, 3) != 0);
      mseq_done = ($urandom_range(0, 3) == 0);
      flush     = ($urandom_range(0, 29) == 0);
      cyc();
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule